// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. Five sources feed it: two external pins (active low), overflow pulses from two timers, and a serial port whose receive and transmit flags arrive as levels. The core programs a source-mask register, a priority register and a pin trigger-mode register through a narrow register port. The block raises a vector request carrying a fixed 16-bit code address and holds it until the core acknowledges it. The core signals the end of a handler with a return strobe.

Each external pin is synchronized. In level mode, a low pin is a request. In edge mode, a high-to-low transition is latched. There are two priority levels. A high-level request preempts a low-level handler. An in-service stack with one slot per level records which handlers are active, and the return strobe pops the most recent one. Timer flags are cleared when their vector is acknowledged. Edge latches are cleared when their handler returns. The serial request is never cleared by the block.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the mask, priority and trigger-mode registers read back as 0x00, and `vec_req_o` is low.
- R2: The register port uses address 0 for the mask register, address 1 for priority and address 2 for trigger mode. A write lands on the clock edge where `reg_we_i` is high. Reads are combinational. In the mask register, bit 7 is the global enable. Bits 0..4 enable, in order: pin 0, timer 0, pin 1, timer 1, serial. The priority register uses the same bits 0..4 (1 = high level). Trigger-mode bit k set to 1 puts pin k in edge mode.
- R3: The vector address is 0x0003 + 8*index. The indices are: pin 0 = 0, timer 0 = 1, pin 1 = 2, timer 1 = 3, serial = 4. This gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R4: No request is raised while the global enable bit is 0, or for a source whose mask bit is 0. A pending flag survives while it is masked and is taken once it is unmasked.
- R5: Among simultaneous requests of the same level, the one with the lowest index wins.
- R6: A high-level request is raised while a low-level handler is active. Once the high handler returns, the low handler is still recorded as active.
- R7: A request whose level is the same as or lower than the active handler's level stays pending until a return strobe.
- R8: In edge mode, a falling edge on the pin latches a request. Edges that arrive while the handler is active are absorbed, and the latch clears on that handler's return, so no second vector follows.
- R9: In level mode, a pin that is still low after the return strobe produces the same vector again. A pin that has gone high produces no further vector.
- R10: A timer overflow pulse yields exactly one vector, because its flag clears when that vector is acknowledged.
- R11: The serial request is the OR of the receive and transmit inputs. The block never clears it, so it is raised again after a return while either input stays high.
- R12: Once `vec_req_o` is high, it and `vec_addr_o` stay unchanged until the cycle `vec_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| ext_ni | input | 2 | External interrupt pins, active low |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| ser_rx_i | input | 1 | Serial receive flag |
| ser_tx_i | input | 1 | Serial transmit flag |
| vec_req_o | output | 1 | Vector request to the core |
| vec_addr_o | output | 16 | Vector code address |
| vec_ack_i | input | 1 | Core accepts the vector |
| reti_i | input | 1 | Return-from-handler strobe |

## Verification
The bench builds the block with its default parameters. Those are two synchronizer stages, a vector base of 0x0003 and a stride of 8, so every vector value named in R3 is observed directly. With the short synchronizer, a three-cycle pin pulse is enough to exercise edge capture. It also lets the bench release a level pin and issue the return strobe a few cycles later, which brings edge absorption during service and level re-triggering after a return within reach of short directed scenarios.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 5;
  localparam int IW      = $clog2(NSRC);
  localparam int NEXT    = 2;
  localparam int NTMR    = 2;
  localparam int GIE_BIT = 7;

  typedef enum logic [IW-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  localparam logic [1:0] RA_MASK = 2'd0;
  localparam logic [1:0] RA_PRI  = 2'd1;
  localparam logic [1:0] RA_MODE = 2'd2;
endpackage

// File: rtl/irq_ext_sense.sv
module irq_ext_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic req_o
);
  localparam int SW = SYNC_STAGES + 1;

  logic [SW-1:0] sh_q;
  logic          flag_q;
  logic          pin_s, pin_prev, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[SW-2:0], pin_ni};
  end

  assign pin_s    = sh_q[SYNC_STAGES-1];
  assign pin_prev = sh_q[SYNC_STAGES];
  assign fall     = pin_prev & ~pin_s;

  // set wins over a return in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            flag_q <= 1'b0;
    else if (!edge_mode_i)  flag_q <= 1'b0;
    else if (fall)          flag_q <= 1'b1;
    else if (clr_i)         flag_q <= 1'b0;
  end

  assign req_o = edge_mode_i ? flag_q : ~pin_s;

  a_r8_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && edge_mode_i && !clr_i) |=> flag_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]         pend_i,
  input  logic [N-1:0]         pri_i,
  input  logic                 gie_i,
  input  logic                 hi_busy_i,
  input  logic                 lo_busy_i,
  output logic                 valid_o,
  output logic                 hi_o,
  output logic [$clog2(N)-1:0] idx_o
);
  logic [N-1:0] hi_c, lo_c, sel_c;

  always_comb begin
    hi_c  = pend_i & pri_i & {N{gie_i}};
    lo_c  = pend_i & ~pri_i & {N{gie_i}};
    sel_c = '0;
    hi_o  = 1'b0;
    if (!hi_busy_i && |hi_c) begin
      sel_c = hi_c;
      hi_o  = 1'b1;
    end else if (!hi_busy_i && !lo_busy_i) begin
      sel_c = lo_c;
    end
    valid_o = |sel_c;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel_c[i]) idx_o = i[$clog2(N)-1:0];
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          push_hi_i,
  input  logic [IW-1:0] push_src_i,
  input  logic          pop_i,
  output logic          hi_busy_o,
  output logic          lo_busy_o,
  output logic          pop_vld_o,
  output logic [IW-1:0] pop_src_o
);
  logic          hi_q, lo_q;
  logic [IW-1:0] hi_src_q, lo_src_q;

  assign pop_vld_o = pop_i & (hi_q | lo_q);
  assign pop_src_o = hi_q ? hi_src_q : lo_src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= 1'b0;
      lo_q     <= 1'b0;
      hi_src_q <= '0;
      lo_src_q <= '0;
    end else begin
      if (pop_i) begin
        if (hi_q)      hi_q <= 1'b0;
        else if (lo_q) lo_q <= 1'b0;
      end
      if (push_i) begin
        if (push_hi_i) begin
          hi_q     <= 1'b1;
          hi_src_q <= push_src_i;
        end else begin
          lo_q     <= 1'b1;
          lo_src_q <= push_src_i;
        end
      end
    end
  end

  assign hi_busy_o = hi_q;
  assign lo_busy_o = lo_q;

  a_r6_low_push_only_when_hi_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !push_hi_i) |-> !hi_q);
  a_r6_hi_pop_keeps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && hi_q && lo_q && !push_i) |=> (lo_q && !hi_q));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_BASE    = 16'h0003,
  parameter logic [15:0] VEC_STRIDE  = 16'h0008
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic [1:0]  ext_ni,
  input  logic [1:0]  tmr_ovf_i,
  input  logic        ser_rx_i,
  input  logic        ser_tx_i,
  output logic        vec_req_o,
  output logic [15:0] vec_addr_o,
  input  logic        vec_ack_i,
  input  logic        reti_i
);
  logic [NSRC-1:0] mask_q, pri_q, pend;
  logic            gie_q;
  logic [NEXT-1:0] mode_q, ext_req, ext_clr;
  logic [NTMR-1:0] tflag_q;

  logic            req_q, lvl_q;
  logic [IW-1:0]   src_q;
  logic            take;

  logic            arb_vld, arb_hi;
  logic [IW-1:0]   arb_idx;
  logic            hi_busy, lo_busy, pop_vld;
  logic [IW-1:0]   pop_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
      pri_q  <= '0;
      mode_q <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        RA_MASK: begin
          mask_q <= reg_wdata_i[NSRC-1:0];
          gie_q  <= reg_wdata_i[GIE_BIT];
        end
        RA_PRI:  pri_q  <= reg_wdata_i[NSRC-1:0];
        RA_MODE: mode_q <= reg_wdata_i[NEXT-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_MASK: begin
        reg_rdata_o[NSRC-1:0] = mask_q;
        reg_rdata_o[GIE_BIT]  = gie_q;
      end
      RA_PRI:  reg_rdata_o[NSRC-1:0] = pri_q;
      RA_MODE: reg_rdata_o[NEXT-1:0] = mode_q;
      default: ;
    endcase
  end

  localparam logic [IW-1:0] EXT_IDX [NEXT] = '{SRC_EXT0, SRC_EXT1};
  localparam logic [IW-1:0] TMR_IDX [NTMR] = '{SRC_TMR0, SRC_TMR1};

  assign take = req_q & vec_ack_i;

  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    assign ext_clr[k] = pop_vld && (pop_src == EXT_IDX[k]);
    irq_ext_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_ni     (ext_ni[k]),
      .edge_mode_i(mode_q[k]),
      .clr_i      (ext_clr[k]),
      .req_o      (ext_req[k])
    );
  end

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           tflag_q[t] <= 1'b0;
      else if (tmr_ovf_i[t])                 tflag_q[t] <= 1'b1;
      else if (take && src_q == TMR_IDX[t])  tflag_q[t] <= 1'b0;
    end
  end

  always_comb begin
    pend           = '0;
    pend[SRC_EXT0] = ext_req[0];
    pend[SRC_TMR0] = tflag_q[0];
    pend[SRC_EXT1] = ext_req[1];
    pend[SRC_TMR1] = tflag_q[1];
    pend[SRC_SER]  = ser_rx_i | ser_tx_i;
    pend           = pend & mask_q;
  end

  irq_arbiter #(.N(NSRC)) u_arb (
    .pend_i   (pend),
    .pri_i    (pri_q),
    .gie_i    (gie_q),
    .hi_busy_i(hi_busy),
    .lo_busy_i(lo_busy),
    .valid_o  (arb_vld),
    .hi_o     (arb_hi),
    .idx_o    (arb_idx)
  );

  irq_nest_stack u_stack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (take),
    .push_hi_i (lvl_q),
    .push_src_i(src_q),
    .pop_i     (reti_i),
    .hi_busy_o (hi_busy),
    .lo_busy_o (lo_busy),
    .pop_vld_o (pop_vld),
    .pop_src_o (pop_src)
  );

  // request is frozen until acknowledged; re-arbitrate one cycle after
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      lvl_q <= 1'b0;
      src_q <= '0;
    end else if (req_q) begin
      if (vec_ack_i) req_q <= 1'b0;
    end else if (arb_vld && !reti_i) begin
      req_q <= 1'b1;
      lvl_q <= arb_hi;
      src_q <= arb_idx;
    end
  end

  assign vec_req_o  = req_q;
  assign vec_addr_o = VEC_BASE + VEC_STRIDE * {{(16-IW){1'b0}}, src_q};

  a_r12_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_o && !vec_ack_i) |=> (vec_req_o && $stable(vec_addr_o)));
  a_r4_gie_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_req_o) |-> $past(gie_q));
  a_r7_hi_blocks_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_req_o) |-> !$past(hi_busy));
  a_r10_tmr0_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && src_q == TMR_IDX[0] && !tmr_ovf_i[0]) |=> !tflag_q[0]);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  tovf = '0;
  logic        rx = 1'b0, tx = 1'b0;
  logic        vreq;
  logic [15:0] vaddr;
  logic        ack = 1'b0, reti = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ext_ni(ext_n), .tmr_ovf_i(tovf), .ser_rx_i(rx), .ser_tx_i(tx),
    .vec_req_o(vreq), .vec_addr_o(vaddr), .vec_ack_i(ack), .reti_i(reti)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a;
    #1 chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic take_vec(input logic [15:0] exp, input string tag);
    bit seen = 0;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk);
      if (vreq) seen = 1;
    end
    chk(seen && vaddr === exp, tag, seen ? int'(vaddr) : -1, exp);
    if (seen) begin
      ack = 1'b1;
      @(negedge clk); ack = 1'b0;
    end
  endtask

  task automatic quiet(input int n, input string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (vreq) hits++;
    end
    chk(hits == 0, tag, hits, 0);
  endtask

  task automatic ret();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic tpulse(input int t);
    @(negedge clk); tovf[t] = 1'b1;
    @(negedge clk); tovf[t] = 1'b0;
  endtask

  task automatic pin0_pulse();
    @(negedge clk); ext_n[0] = 1'b0;
    repeat (3) @(negedge clk);
    ext_n[0] = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rd(2'd0, 8'h00, "R1 mask reset");
    rd(2'd1, 8'h00, "R1 pri reset");
    rd(2'd2, 8'h00, "R1 mode reset");
    chk(vreq === 1'b0, "R1 no request", vreq, 0);
  endtask

  task automatic t_regs();
    wr(2'd0, 8'h83); rd(2'd0, 8'h83, "R2 mask write");
    wr(2'd1, 8'h15); rd(2'd1, 8'h15, "R2 pri write");
    wr(2'd2, 8'h02); rd(2'd2, 8'h02, "R2 mode write");
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_gate();
    wr(2'd0, 8'h02);
    tpulse(0);
    quiet(8, "R4 global enable off");
    wr(2'd0, 8'h82);
    take_vec(16'h000B, "R3 R4 timer0 after unmask");
    ret();
    quiet(8, "R10 timer flag cleared");
    wr(2'd0, 8'h00);
  endtask

  task automatic t_order();
    ext_n[1] = 1'b0; rx = 1'b1;
    tpulse(0); tpulse(1);
    quiet(6, "R4 all masked");
    wr(2'd0, 8'h9F);
    take_vec(16'h000B, "R5 timer0 first");
    quiet(6, "R7 same level held");
    ret();
    take_vec(16'h0013, "R5 R9 pin1 level second");
    ext_n[1] = 1'b1;
    repeat (4) @(negedge clk);
    ret();
    take_vec(16'h001B, "R5 timer1 third");
    ret();
    take_vec(16'h0023, "R5 serial last");
    ret();
    take_vec(16'h0023, "R11 serial not cleared");
    rx = 1'b0;
    ret();
    quiet(8, "R11 serial idle after clear");
    wr(2'd0, 8'h00);
  endtask

  task automatic t_preempt();
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h92);
    tpulse(0);
    take_vec(16'h000B, "R6 low handler");
    tx = 1'b1;
    take_vec(16'h0023, "R6 high preempts low");
    tpulse(0);
    quiet(6, "R7 low held under high");
    tx = 1'b0;
    ret();
    quiet(6, "R6 R7 low still active");
    ret();
    take_vec(16'h000B, "R7 low taken after return");
    ret();
    quiet(6, "R10 single timer vector");
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
  endtask

  task automatic t_edge();
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h81);
    pin0_pulse();
    take_vec(16'h0003, "R8 edge latched");
    pin0_pulse(); pin0_pulse();
    quiet(4, "R8 edges absorbed in service");
    ret();
    quiet(8, "R8 latch cleared on return");
    pin0_pulse();
    take_vec(16'h0003, "R8 new edge after return");
    ret();
    quiet(6, "R8 no repeat");
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_level();
    wr(2'd0, 8'h81);
    @(negedge clk); ext_n[0] = 1'b0;
    take_vec(16'h0003, "R9 level request");
    repeat (3) @(negedge clk);
    ret();
    take_vec(16'h0003, "R9 level retaken");
    ext_n[0] = 1'b1;
    repeat (4) @(negedge clk);
    ret();
    quiet(8, "R9 released pin idle");
    wr(2'd0, 8'h00);
  endtask

  task automatic t_hold();
    int moved = 0;
    wr(2'd0, 8'h82);
    tpulse(0);
    for (int i = 0; i < 20 && !vreq; i++) @(negedge clk);
    wr(2'd0, 8'h9F); rx = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!vreq || vaddr !== 16'h000B) moved++;
    end
    chk(moved == 0, "R12 held until ack", moved, 0);
    take_vec(16'h000B, "R12 ack accepted");
    rx = 1'b0;
    ret();
    quiet(6, "R12 idle after return");
    wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gate();
    t_order();
    t_preempt();
    t_edge();
    t_level();
    t_hold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule